// File: doc/BRIEF.md
# Nibble-Mode Parallel Link Transmitter

This block sends byte packets across a narrow parallel link made of four data lines plus one request line outward and one acknowledge line coming back. Each byte is split into two nibbles. The upper nibble goes first together with a rising request. The lower nibble follows together with a falling request. Each nibble edge waits for the remote side to mirror the request level on its acknowledge line. The remote acknowledge is asynchronous, so it passes through a flop synchronizer before the state machine uses it.

The upstream source offers payload bytes on a valid/ready stream with a last flag. A pending byte starts a packet. The block then sends a fixed two-byte prefix (0x08 followed by 0x00) and only after that pulls the payload bytes. No separate start marker exists. After the final low nibble has been acknowledged, the block puts the bitwise inverse of that nibble on the data lines and leaves the request line low. This in-band marker ends the packet. The marker is held for a programmable number of cycles, after which the lines return to zero. If the remote side stops answering, a programmable watchdog abandons the packet and raises a one-cycle error pulse.

Top module: `nib_link_tx`

## Requirements
- R1: Out of reset and whenever no packet is in progress, `data_o` is 0, `hs_o` is 0, `err_o` is 0 and `byte_ready_o` is 0.
- R2: Every packet puts on the line the prefix bytes 0x08 and then 0x00, followed directly by the payload bytes in stream order. The first prefix nibble, with `hs_o` rising, is the only start indication.
- R3: For each byte, bits [7:4] appear on `data_o` in the same cycle that `hs_o` rises. The block holds them until the synchronized acknowledge is high.
- R4: Once the synchronized acknowledge is high, bits [3:0] appear in the same cycle that `hs_o` falls. The next byte does not begin until the synchronized acknowledge is low again.
- R5: While a byte is in flight, `data_o` only changes in a cycle where `hs_o` also changes. The end marker is the one exception.
- R6: After the low nibble of the byte flagged last is acknowledged low, `data_o` becomes the bitwise inverse of that nibble while `hs_o` stays 0. The marker is held for exactly `hold_cycles_i` cycles (at least 1), then `data_o` returns to 0.
- R7: If the synchronized acknowledge fails to reach the awaited level within `timeout_cycles_i` cycles (at least 1), then on the next cycle `err_o` pulses high for exactly one cycle, `data_o` and `hs_o` go to 0 and the block returns to idle. A following packet is sent normally.
- R8: `remote_hs_i` passes through two flops before the state machine acts on it. A level change driven between clock edges moves `hs_o` after the third following rising edge.
- R9: While the upstream source withholds the next payload byte, the lines keep the previous low nibble with `hs_o` at 0. No timeout is counted during that wait.
- R10: `byte_ready_o` is asserted only together with `byte_valid_i`, and only while a payload byte is being taken. It is asserted once for every payload byte and never for a prefix byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte present |
| byte_last_i | input | 1 | Payload byte is the final one of the packet |
| byte_ready_o | output | 1 | Payload byte taken at this edge |
| hold_cycles_i | input | 8 | End-marker hold length in cycles, at least 1 |
| timeout_cycles_i | input | 16 | Acknowledge wait limit in cycles, at least 1 |
| remote_hs_i | input | 1 | Remote acknowledge, asynchronous |
| data_o | output | 4 | Nibble data lines |
| hs_o | output | 1 | Outgoing request line |
| err_o | output | 1 | One-cycle pulse on handshake timeout |

## Verification
The bench acts as the remote receiver. It samples on falling edges and drives the acknowledge there. Every nibble edge of the block therefore arrives three rising edges after the bench changes the acknowledge: two synchronizer flops plus the state register. The bench measures that count directly for both the rising and the falling request.

For a timeout, counting starts at the first falling edge that shows the new request level. The error pulse is due at sample `timeout_cycles_i + 1` and must be gone one sample later. The end marker is counted sample by sample and must last exactly `hold_cycles_i` samples before zero returns. The bench flags any data change seen while the request level is steady.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_EOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/nib_link_sync.sv
module nib_link_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], async_i};
  end

  assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/nib_link_timer.sv
module nib_link_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/nib_link_src.sv
module nib_link_src #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned HDR_LEN  = 2,
  parameter logic [HDR_LEN*BYTE_W-1:0] HDR_WORD = 16'h0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              clear_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic [BYTE_W-1:0] nxt_byte_o,
  output logic              nxt_last_o,
  output logic              nxt_avail_o,
  output logic              ready_o
);
  localparam int unsigned IW = $clog2(HDR_LEN + 1);

  logic [IW-1:0] idx_q;
  logic          in_hdr;

  assign in_hdr      = idx_q < IW'(HDR_LEN);
  assign nxt_byte_o  = in_hdr ? HDR_WORD[(HDR_LEN - 1 - int'(idx_q)) * BYTE_W +: BYTE_W] : byte_i;
  assign nxt_last_o  = !in_hdr && last_i;
  assign nxt_avail_o = in_hdr || valid_i;
  assign ready_o     = take_i && !in_hdr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_q <= '0;
    else if (clear_i)           idx_q <= '0;
    else if (take_i && in_hdr)  idx_q <= idx_q + IW'(1);
  end

  // payload taken only when offered
  p_ready_with_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> valid_i);
  // prefix index never runs past the prefix length
  p_idx_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(HDR_LEN));
endmodule

// File: rtl/nib_link_tx.sv
module nib_link_tx
  import nib_link_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned HOLD_W      = 8,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HDR_LEN     = 2,
  parameter logic [HDR_LEN*BYTE_W-1:0] HDR_WORD = 16'h0800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_valid_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic [TO_W-1:0]   timeout_cycles_i,
  input  logic              remote_hs_i,
  output logic [BYTE_W/2-1:0] data_o,
  output logic              hs_o,
  output logic              err_o
);
  localparam int unsigned NIB_W = BYTE_W / 2;

  tx_state_e         state_q, state_d;
  logic [NIB_W-1:0]  data_q, data_d;
  logic              hs_q, hs_d;
  logic [BYTE_W-1:0] cur_q, cur_d;
  logic              last_q, last_d;
  logic              err_q, err_d;

  logic              ack_s;
  logic              take, clear;
  logic [BYTE_W-1:0] nxt_byte;
  logic              nxt_last, nxt_avail;
  logic              to_run, to_exp;
  logic              hold_run, hold_exp;

  nib_link_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (remote_hs_i),
    .sync_o  (ack_s)
  );

  nib_link_src #(.BYTE_W(BYTE_W), .HDR_LEN(HDR_LEN), .HDR_WORD(HDR_WORD)) i_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .clear_i     (clear),
    .byte_i      (byte_i),
    .valid_i     (byte_valid_i),
    .last_i      (byte_last_i),
    .nxt_byte_o  (nxt_byte),
    .nxt_last_o  (nxt_last),
    .nxt_avail_o (nxt_avail),
    .ready_o     (byte_ready_o)
  );

  assign to_run   = ((state_q == ST_HI) && !ack_s) || ((state_q == ST_LO) && ack_s);
  assign hold_run = (state_q == ST_EOP);

  nib_link_timer #(.W(TO_W)) i_to_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (to_run),
    .limit_i   (timeout_cycles_i),
    .expired_o (to_exp)
  );

  nib_link_timer #(.W(HOLD_W)) i_hold_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (hold_run),
    .limit_i   (hold_cycles_i - HOLD_W'(1)),
    .expired_o (hold_exp)
  );

  always_comb begin
    state_d = state_q;
    data_d  = data_q;
    hs_d    = hs_q;
    cur_d   = cur_q;
    last_d  = last_q;
    err_d   = 1'b0;
    take    = 1'b0;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (byte_valid_i) begin
        take    = 1'b1;
        cur_d   = nxt_byte;
        last_d  = nxt_last;
        data_d  = nxt_byte[BYTE_W-1 -: NIB_W];
        hs_d    = 1'b1;
        state_d = ST_HI;
      end
      ST_HI: if (to_exp) begin
        state_d = ST_IDLE; data_d = '0; hs_d = 1'b0; err_d = 1'b1; clear = 1'b1;
      end else if (ack_s) begin
        data_d  = cur_q[NIB_W-1:0];
        hs_d    = 1'b0;
        state_d = ST_LO;
      end
      ST_LO: if (to_exp) begin
        state_d = ST_IDLE; data_d = '0; hs_d = 1'b0; err_d = 1'b1; clear = 1'b1;
      end else if (!ack_s) begin
        if (last_q) begin
          // in-band end marker: invert lines, request stays low
          data_d  = ~cur_q[NIB_W-1:0];
          state_d = ST_EOP;
        end else if (nxt_avail) begin
          take    = 1'b1;
          cur_d   = nxt_byte;
          last_d  = nxt_last;
          data_d  = nxt_byte[BYTE_W-1 -: NIB_W];
          hs_d    = 1'b1;
          state_d = ST_HI;
        end
      end
      ST_EOP: if (hold_exp) begin
        data_d  = '0;
        state_d = ST_IDLE;
        clear   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // data and request share one register stage so they move on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      hs_q    <= 1'b0;
      cur_q   <= '0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      data_q  <= data_d;
      hs_q    <= hs_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
      err_q   <= err_d;
    end
  end

  assign data_o = data_q;
  assign hs_o   = hs_q;
  assign err_o  = err_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (data_o == '0 && !hs_o));
  p_rise_after_low_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !$past(ack_s));
  p_fall_after_high_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_o) |-> ($past(ack_s) || err_o));
  p_data_with_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HI || state_q == ST_LO) &&
     ($past(state_q) == ST_HI || $past(state_q) == ST_LO) &&
     (data_o != $past(data_o))) |-> (hs_o != $past(hs_o)));
  p_eop_hs_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EOP) |-> !hs_o);
  p_eop_inverts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_EOP) && ($past(state_q) == ST_LO)) |-> (data_o == ~$past(data_o)));
  p_err_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (data_o == '0 && !hs_o && state_q == ST_IDLE));
  p_stall_no_timeout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_LO) && !ack_s) |-> !to_exp);
endmodule

// File: tb/test_nib_link_tx.sv
module test_nib_link_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_valid_i = 1'b0;
  logic       byte_last_i = 1'b0;
  logic       byte_ready_o;
  logic [7:0] hold_cycles_i = 8'd4;
  logic [15:0] timeout_cycles_i = 16'd10;
  logic       remote_hs = 1'b0;
  logic [3:0] data_o;
  logic       hs_o;
  logic       err_o;

  int total = 0, bad = 0;
  int err_seen = 0, ready_cnt = 0, cycles = 0;
  logic [7:0] pay [16];
  logic [7:0] rx_buf [16];
  int rx_n, eop_len, glitch;
  logic [3:0] eop_nib;

  always #5 clk_i = ~clk_i;

  nib_link_tx i_nib_link_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o), .hold_cycles_i(hold_cycles_i),
    .timeout_cycles_i(timeout_cycles_i), .remote_hs_i(remote_hs), .data_o(data_o),
    .hs_o(hs_o), .err_o(err_o)
  );

  always @(negedge clk_i) if (err_o) err_seen++;

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
        finish_run();
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tx_payload(input int n, input int gap_at, input int gap);
    for (int i = 0; i < n; i++) begin
      if (i == gap_at) repeat (gap) @(negedge clk_i);
      byte_i = pay[i]; byte_valid_i = 1'b1; byte_last_i = (i == n - 1);
      #1;
      while (!byte_ready_o) begin @(negedge clk_i); #1; end
      @(posedge clk_i);
      ready_cnt++;
      @(negedge clk_i);
      byte_valid_i = 1'b0; byte_last_i = 1'b0;
    end
  endtask

  // remote receiver model; samples and drives on falling edges
  task automatic rx_packet(input int dly);
    logic [3:0] hi, lo;
    logic have, done;
    hi = '0; lo = '0; have = 1'b0; done = 1'b0;
    rx_n = 0; eop_len = 0; glitch = 0; eop_nib = '0;
    while (!done) begin
      @(negedge clk_i);
      if (hs_o && !remote_hs) begin
        hi = data_o;
        for (int k = 0; k < dly; k++) begin
          @(negedge clk_i);
          if (data_o !== hi || !hs_o) glitch++;
        end
        remote_hs = 1'b1;
      end else if (!hs_o && remote_hs) begin
        lo = data_o;
        rx_buf[rx_n] = {hi, lo}; rx_n++; have = 1'b1;
        for (int k = 0; k < dly; k++) begin
          @(negedge clk_i);
          if (data_o !== lo || hs_o) glitch++;
        end
        remote_hs = 1'b0;
      end else if (!hs_o && !remote_hs && have && data_o === ~lo) begin
        eop_nib = data_o;
        while (!hs_o && data_o === ~lo) begin eop_len++; @(negedge clk_i); end
        if (data_o !== 4'h0 || hs_o) glitch++;
        done = 1'b1;
      end else if (hs_o && remote_hs && data_o !== hi) glitch++;
      else if (!hs_o && !remote_hs && have && data_o !== lo) glitch++;
    end
  endtask

  task automatic t_reset();
    chk("R1 data idle", 32'(data_o), 0);
    chk("R1 hs idle", 32'(hs_o), 0);
    chk("R1 err idle", 32'(err_o), 0);
    chk("R1 ready idle", 32'(byte_ready_o), 0);
  endtask

  task automatic t_single();
    pay[0] = 8'hA5; hold_cycles_i = 8'd4; ready_cnt = 0;
    fork tx_payload(1, -1, 0); rx_packet(0); join
    chk("R2 count", 32'(rx_n), 3);
    chk("R2 hdr0", 32'(rx_buf[0]), 32'h08);
    chk("R2 hdr1", 32'(rx_buf[1]), 32'h00);
    chk("R3 R4 payload", 32'(rx_buf[2]), 32'hA5);
    chk("R6 marker", 32'(eop_nib), 32'hA);
    chk("R6 hold", 32'(eop_len), 4);
    chk("R5 steady", 32'(glitch), 0);
    chk("R10 ready count", 32'(ready_cnt), 1);
  endtask

  task automatic t_multi();
    pay[0] = 8'h3C; pay[1] = 8'hFF; pay[2] = 8'h00; pay[3] = 8'h7E;
    hold_cycles_i = 8'd1; ready_cnt = 0;
    fork tx_payload(4, -1, 0); rx_packet(2); join
    chk("R2 count", 32'(rx_n), 6);
    chk("R2 hdr0", 32'(rx_buf[0]), 32'h08);
    for (int i = 0; i < 4; i++) chk("R3 R4 payload", 32'(rx_buf[i+2]), 32'(pay[i]));
    chk("R6 marker", 32'(eop_nib), 32'h1);
    chk("R6 hold", 32'(eop_len), 1);
    chk("R5 steady", 32'(glitch), 0);
    chk("R10 ready count", 32'(ready_cnt), 4);
  endtask

  task automatic t_stall();
    int e0;
    pay[0] = 8'h12; pay[1] = 8'h34; hold_cycles_i = 8'd2; ready_cnt = 0; e0 = err_seen;
    fork tx_payload(2, 1, 30); rx_packet(0); join
    chk("R9 no error", 32'(err_seen - e0), 0);
    chk("R9 count", 32'(rx_n), 4);
    chk("R9 byte2", 32'(rx_buf[2]), 32'h12);
    chk("R9 byte3", 32'(rx_buf[3]), 32'h34);
    chk("R9 lines held", 32'(glitch), 0);
    chk("R6 marker", 32'(eop_nib), 32'hB);
  endtask

  task automatic t_latency();
    int lat;
    pay[0] = 8'h5A; hold_cycles_i = 8'd3;
    fork
      tx_payload(1, -1, 0);
      begin
        while (!hs_o) @(negedge clk_i);
        remote_hs = 1'b1; lat = 0;
        while (hs_o && lat < 20) begin @(negedge clk_i); lat++; end
        chk("R8 fall latency", 32'(lat), 3);
        chk("R4 low nibble", 32'(data_o), 32'h8);
        remote_hs = 1'b0; lat = 0;
        while (!hs_o && lat < 20) begin @(negedge clk_i); lat++; end
        chk("R8 rise latency", 32'(lat), 3);
        rx_packet(0);
        chk("R2 rest", 32'(rx_buf[1]), 32'h5A);
        chk("R6 hold", 32'(eop_len), 3);
      end
    join
  endtask

  task automatic t_timeout_hi();
    int n;
    timeout_cycles_i = 16'd10;
    @(negedge clk_i);
    byte_i = 8'h99; byte_valid_i = 1'b1; byte_last_i = 1'b1;
    while (!hs_o) @(negedge clk_i);
    n = 0;
    while (!err_o && n < 50) begin @(negedge clk_i); n++; end
    byte_valid_i = 1'b0; byte_last_i = 1'b0;
    chk("R7 hi timeout cycles", 32'(n), 11);
    chk("R7 hs cleared", 32'(hs_o), 0);
    @(negedge clk_i);
    chk("R7 single pulse", 32'(err_o), 0);
  endtask

  task automatic t_timeout_lo();
    int n;
    @(negedge clk_i);
    byte_i = 8'h66; byte_valid_i = 1'b1; byte_last_i = 1'b1;
    while (!hs_o) @(negedge clk_i);
    remote_hs = 1'b1;
    while (hs_o) @(negedge clk_i);
    chk("R4 low nibble before abort", 32'(data_o), 32'h8);
    n = 0;
    while (!err_o && n < 50) begin @(negedge clk_i); n++; end
    byte_valid_i = 1'b0; byte_last_i = 1'b0;
    chk("R7 lo timeout cycles", 32'(n), 11);
    chk("R7 data cleared", 32'(data_o), 0);
    remote_hs = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R1 idle after abort", 32'({data_o, hs_o, err_o}), 0);
  endtask

  task automatic t_recover();
    pay[0] = 8'hC3; hold_cycles_i = 8'd2; ready_cnt = 0;
    fork tx_payload(1, -1, 0); rx_packet(0); join
    chk("R7 recover hdr0", 32'(rx_buf[0]), 32'h08);
    chk("R7 recover payload", 32'(rx_buf[2]), 32'hC3);
    chk("R6 marker", 32'(eop_nib), 32'hC);
    chk("R10 ready count", 32'(ready_cnt), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_single();
    repeat (3) @(negedge clk_i);
    t_multi();
    repeat (3) @(negedge clk_i);
    t_stall();
    repeat (3) @(negedge clk_i);
    t_latency();
    repeat (3) @(negedge clk_i);
    t_timeout_hi();
    repeat (3) @(negedge clk_i);
    t_timeout_lo();
    t_recover();
    finish_run();
  end
endmodule